// File: doc/BRIEF.md
# UART Bit-Timing and Sample-Strobe Generator

This block sets the bit timing for a 16550-style serial port. A 16-bit divisor makes a prescaled tick. A highspeed mode register then sets how many ticks form one bit: 16 ticks, 4 ticks, or a programmable count. The block has two outputs. The first is a bit-boundary strobe that paces the transmitter. The second is a strobe at the receive sample point, and it re-aligns to every falling edge of the synchronised receive line.

Software reaches the block through a register port of 32-bit words. A register's byte address is its index shifted left by two. The divisor bytes can only be reached while the divisor-access bit of the line control register is set. A rate-fix register must be written to zero before any timing runs. Character framing, FIFOs and interrupts belong to neighbouring blocks.

Top module: `uart_bit_timer`

## Requirements
- R1: After reset the divisor is 0, the line control register is 0x00, the mode register is 0, sample count is 0x00, sample point is 0xff, rate-fix is 0x01, and both strobes are low.
- R2: A register with index I sits at byte address I<<2. The indices are: 0 divisor low byte, 1 divisor high byte, 3 line control, 9 highspeed mode (bits 1:0), 10 sample count, 11 sample point, 13 rate-fix. Read-data bits above a register's width read 0.
- R3: Bit 7 of line control opens the divisor. While that bit is 0, writes to index 0 and 1 leave the divisor unchanged and reads of them return 0.
- R4: A tick occurs once every D clock cycles, where D is the divisor. While D is 0, neither strobe ever rises.
- R5: The ticks per bit (T) depend on the mode. Mode 0 or 1 gives T = 16. Mode 2 gives T = 4. Mode 3 gives T = sample count + 1. The transmit strobe is high for one cycle, and strobes repeat every T*D cycles.
- R6: A write to the divisor (while open), mode, sample count, sample point or rate-fix restarts the prescaler and both bit counters. The first transmit strobe is then high in cycle T*D after the write edge, where the cycle after the write edge is cycle 1.
- R7: The receive line passes through SYNC_STAGES flops. Each falling edge at the output of the sync chain restarts the receive bit counter. The receive strobe fires on the tick whose index within the bit equals the sample point S. In modes 0, 1 and 2, S = (T-2)>>1. In mode 3, S is the sample point register. If S >= T, no receive strobe occurs.
- R8: While rate-fix is nonzero both strobes stay low. Writing 0 to rate-fix lets plain divisor timing run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write enable, one per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| rx_line | input | 1 | Asynchronous serial receive line |
| tx_bit_stb | output | 1 | One-cycle strobe at each transmit bit boundary |
| rx_sample_stb | output | 1 | One-cycle strobe at the receive sample point |

## Verification
The in-line assertions check four things on every cycle. The prescaler and bit counters stay within the limits the current divisor and mode allow. A zero divisor or a nonzero rate-fix keeps both strobes silent. A protected divisor write changes nothing. The cycle right after a falling-edge re-alignment carries no receive strobe unless the sample point is zero. The bench scenarios are the only way to show the exact strobe cycle counts after a configuration write. They also show the period for each mode and divisor, and the receive strobe position after a start edge, including a sample point outside the bit.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   typedef enum logic [1:0] {
      HS_X16  = 2'd0,
      HS_X16B = 2'd1,
      HS_X4   = 2'd2,
      HS_PROG = 2'd3
   } hs_mode_e;

   localparam int IDX_DLL  = 0;
   localparam int IDX_DLM  = 1;
   localparam int IDX_LCR  = 3;
   localparam int IDX_MODE = 9;
   localparam int IDX_CNT  = 10;
   localparam int IDX_PT   = 11;
   localparam int IDX_FIX  = 13;
   localparam int LCR_DL_BIT = 7;
endpackage

// File: rtl/ubt_regs.sv
module ubt_regs
   import ubt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DIV_W  = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [DIV_W-1:0]  divisor,
   output logic [1:0]        mode,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  point,
   output logic              fix_on,
   output logic              cfg_clr
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic [7:0]       lcr;
   logic [7:0]       fix;
   logic             dl_open;
   logic             h_dll, h_dlm, h_lcr, h_mode, h_cnt, h_pt, h_fix;
   logic             unused_bits;

   assign idx      = addr[ADDR_W-1:2];
   assign dl_open  = lcr[LCR_DL_BIT];
   assign unused_bits = ^{wdata[31:8], addr[1:0]};

   always_comb begin
      h_dll  = (idx == IDX_W'(IDX_DLL));
      h_dlm  = (idx == IDX_W'(IDX_DLM));
      h_lcr  = (idx == IDX_W'(IDX_LCR));
      h_mode = (idx == IDX_W'(IDX_MODE));
      h_cnt  = (idx == IDX_W'(IDX_CNT));
      h_pt   = (idx == IDX_W'(IDX_PT));
      h_fix  = (idx == IDX_W'(IDX_FIX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor <= '0;
         lcr     <= '0;
         mode    <= '0;
         count   <= '0;
         point   <= '1;
         fix     <= 8'h01;
      end else if (wr) begin
         if (h_dll && dl_open) divisor[7:0]       <= wdata[7:0];
         if (h_dlm && dl_open) divisor[DIV_W-1:8] <= wdata[DIV_W-9:0];
         if (h_lcr)  lcr   <= wdata[7:0];
         if (h_mode) mode  <= wdata[1:0];
         if (h_cnt)  count <= wdata[CNT_W-1:0];
         if (h_pt)   point <= wdata[CNT_W-1:0];
         if (h_fix)  fix   <= wdata[7:0];
      end
   end

   assign fix_on  = (fix != 8'h00);
   assign cfg_clr = wr && (((h_dll || h_dlm) && dl_open) || h_mode || h_cnt || h_pt || h_fix);

   always_comb begin
      rdata = '0;
      if (h_dll && dl_open) rdata[7:0]       = divisor[7:0];
      if (h_dlm && dl_open) rdata[DIV_W-9:0] = divisor[DIV_W-1:8];
      if (h_lcr)  rdata[7:0]       = lcr;
      if (h_mode) rdata[1:0]       = mode;
      if (h_cnt)  rdata[CNT_W-1:0] = count;
      if (h_pt)   rdata[CNT_W-1:0] = point;
      if (h_fix)  rdata[7:0]       = fix;
   end

   AST_DL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (h_dll || h_dlm) && !dl_open) |=> divisor == $past(divisor)); // R3
endmodule

// File: rtl/ubt_prescale.sv
module ubt_prescale #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] pre;
   logic             run;

   assign run  = (divisor != '0) && !hold;
   assign tick = run && (pre == divisor - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pre <= '0;
      else if (clr || !run || tick) pre <= '0;
      else                          pre <= pre + DIV_W'(1);
   end

   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> pre < divisor); // R4
endmodule

// File: rtl/ubt_bitcount.sv
module ubt_bitcount
   import ubt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] point,
   input  logic             rx_line,
   output logic             tx_stb,
   output logic             rx_stb
);
   logic [CNT_W-1:0]       last, spt, tx_cnt, rx_cnt;
   logic [SYNC_STAGES-1:0] sync;
   logic                   rx_prev, fall;

   always_comb begin
      case (mode)
         HS_PROG: last = count;
         HS_X4:   last = CNT_W'(3);
         default: last = CNT_W'(15);
      endcase
      if (mode == HS_PROG) spt = point;
      else                 spt = (last - CNT_W'(1)) >> 1;
   end

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync <= '1;
         else        sync <= rx_line;
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync <= '1;
         else        sync <= {sync[SYNC_STAGES-2:0], rx_line};
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= sync[SYNC_STAGES-1];

   assign fall = rx_prev && !sync[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_cnt <= '0;
         rx_cnt <= '0;
      end else if (clr) begin
         tx_cnt <= '0;
         rx_cnt <= '0;
      end else begin
         if (tick) tx_cnt <= (tx_cnt == last) ? '0 : tx_cnt + CNT_W'(1);
         if (fall)      rx_cnt <= '0;
         else if (tick) rx_cnt <= (rx_cnt == last) ? '0 : rx_cnt + CNT_W'(1);
      end
   end

   assign tx_stb = tick && (tx_cnt == last);
   assign rx_stb = tick && (rx_cnt == spt);

   AST_TXCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= last); // R5
   AST_RX_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fall) && !$past(clr) && spt != '0) |-> !rx_stb); // R7
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
   parameter int ADDR_W      = 6,
   parameter int DIV_W       = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_line,
   output logic              tx_bit_stb,
   output logic              rx_sample_stb
);
   if (ADDR_W < 6)                begin : g_bad_addr $error("ADDR_W must reach index 13"); end
   if (DIV_W < 9 || DIV_W > 16)   begin : g_bad_div  $error("DIV_W must be 9..16"); end
   if (CNT_W < 4 || CNT_W > 8)    begin : g_bad_cnt  $error("CNT_W must be 4..8"); end
   if (SYNC_STAGES < 1)           begin : g_bad_sync $error("SYNC_STAGES must be >= 1"); end

   logic [DIV_W-1:0] divisor;
   logic [1:0]       mode;
   logic [CNT_W-1:0] count, point;
   logic             fix_on, cfg_clr, tick;

   ubt_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
      .rdata(reg_rdata), .divisor(divisor), .mode(mode), .count(count),
      .point(point), .fix_on(fix_on), .cfg_clr(cfg_clr));

   ubt_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .hold(fix_on),
      .divisor(divisor), .tick(tick));

   ubt_bitcount #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_bits (
      .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .tick(tick), .mode(mode),
      .count(count), .point(point), .rx_line(rx_line),
      .tx_stb(tx_bit_stb), .rx_stb(rx_sample_stb));

   AST_ZERO_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0) |-> (!tx_bit_stb && !rx_sample_stb)); // R4
   AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fix_on |-> (!tx_bit_stb && !rx_sample_stb)); // R8
endmodule

// File: tb/sim_uart_bit_timer.sv
module sim_uart_bit_timer;
   localparam int SYNC = 2;
   localparam int NV   = 9;
   // {mode, sample count, divisor}
   localparam logic [31:0] VEC [NV] = '{
      {8'd0, 8'd0,  16'd1},
      {8'd0, 8'd0,  16'd3},
      {8'd2, 8'd0,  16'd1},
      {8'd2, 8'd0,  16'd5},
      {8'd3, 8'd9,  16'd2},
      {8'd3, 8'd0,  16'd4},
      {8'd1, 8'd0,  16'd2},
      {8'd3, 8'd12, 16'd1},
      {8'd2, 8'd0,  16'h0102}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rx_line = 1'b1;
   logic        tx_bit_stb, rx_sample_stb;
   int          n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   uart_bit_timer #(.SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_line(rx_line),
      .tx_bit_stb(tx_bit_stb), .rx_sample_stb(rx_sample_stb));

   task automatic chk(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr32(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 6'(idx << 2); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wr8(input int idx, input logic [7:0] d);
      wr32(idx, {24'd0, d});
   endtask

   task automatic rd(input int idx, output logic [31:0] v);
      @(negedge clk);
      reg_addr = 6'(idx << 2);
      #1 v = reg_rdata;
   endtask

   // call right after a write: k = 1 is the cycle after the write edge
   task automatic first_tx(output int n);
      n = 0;
      for (int k = 1; k <= 3000; k++) begin
         if (k > 1) @(negedge clk);
         #1;
         if (tx_bit_stb === 1'b1) begin n = k; break; end
      end
   endtask

   task automatic quiet(input int cyc, output int hits);
      hits = 0;
      for (int k = 0; k < cyc; k++) begin
         @(negedge clk); #1;
         if (tx_bit_stb !== 1'b0 || rx_sample_stb !== 1'b0) hits++;
      end
   endtask

   task automatic set_div(input logic [15:0] d);
      wr8(3, 8'h80); wr8(0, d[7:0]); wr8(1, d[15:8]); wr8(3, 8'h00);
   endtask

   task automatic rx_case(input int m, input int cnt, input int pt, input int exp);
      int found;
      set_div(16'd1);
      wr8(10, 8'(cnt)); wr8(11, 8'(pt)); wr8(9, 8'(m));
      repeat (5) @(negedge clk);
      rx_line = 1'b0;
      found = 0;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk); #1;
         if (k >= SYNC + 1 && found == 0 && rx_sample_stb === 1'b1) found = k;
      end
      chk("R7 rx sample position", found, exp);
      rx_line = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n, p, hits, t, d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1 chk("R1 tx strobe low", tx_bit_stb, 0);
      chk("R1 rx strobe low", rx_sample_stb, 0);
      rd(3, v);  chk("R1 line control", v, 0);
      rd(9, v);  chk("R1 mode", v, 0);
      rd(10, v); chk("R1 sample count", v, 0);
      rd(11, v); chk("R1 sample point", v, 32'hff);
      rd(13, v); chk("R1 rate-fix", v, 1);

      // R3 divisor guarded by line control bit 7
      wr8(0, 8'h77);
      rd(0, v); chk("R3 closed read", v, 0);
      wr8(3, 8'h80);
      rd(0, v); chk("R3 closed write ignored", v, 0);
      rd(3, v); chk("R2 line control readback", v, 32'h80);
      wr8(0, 8'h02); wr8(1, 8'h00);
      rd(0, v); chk("R3 open write", v, 2);
      wr8(3, 8'h00);

      // R8 rate-fix nonzero holds both strobes
      wr8(9, 8'd2);
      rx_line = 1'b0;
      quiet(50, hits);
      chk("R8 held while rate-fix set", hits, 0);
      rx_line = 1'b1;
      repeat (5) @(negedge clk);
      wr8(13, 8'h00);
      first_tx(n);
      chk("R8 runs after rate-fix cleared", n, 8);

      // R2 upper read bits zero
      wr32(10, 32'hFFFF_FFFF);
      rd(10, v); chk("R2 upper bits zero", v, 32'hff);
      wr8(10, 8'h00);

      // R5/R6 table of modes and divisors
      for (int i = 0; i < NV; i++) begin
         int m, c;
         m = int'(VEC[i][31:24]);
         c = int'(VEC[i][23:16]);
         d = int'(VEC[i][15:0]);
         t = (m == 3) ? c + 1 : (m == 2) ? 4 : 16;
         set_div(16'(d));
         wr8(10, 8'(c));
         wr8(9, 8'(m));
         first_tx(n);
         chk($sformatf("R6 first strobe vec %0d", i), n, t * d);
         p = 0;
         for (int k = 1; k <= 3000; k++) begin
            @(negedge clk); #1;
            if (tx_bit_stb === 1'b1) begin p = k; break; end
         end
         chk($sformatf("R5 period vec %0d", i), p, t * d);
      end

      // R4 zero divisor silences both strobes
      set_div(16'd0);
      wr8(9, 8'd2);
      rx_line = 1'b0;
      quiet(60, hits);
      chk("R4 zero divisor quiet", hits, 0);
      rx_line = 1'b1;
      repeat (5) @(negedge clk);

      // R7 receive sample strobe after a falling edge
      rx_case(2, 0, 8'hff, SYNC + 1 + 1);
      rx_case(0, 0, 8'hff, SYNC + 1 + 7);
      rx_case(3, 9, 3, SYNC + 1 + 3);
      rx_case(3, 3, 8'hff, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule